// File: doc/BRIEF.md
# Edge-Refreshed Watchdog Supervisor

This block supervises a processor through a single refresh line and drives an active-low reset back to it. It stays out of the way until the supervised supply rail is reported good and a fixed reset period has run out. It then waits for the processor to show life with a rising refresh edge. From that point on, every change on the refresh line restarts a timeout. If the line sits still for too long, the block produces a reset pulse of fixed length.

After a timeout pulse the watchdog is disarmed again and needs a new rising edge before it starts counting. A rail that drops out at any time forces reset, clears all timing and starts the whole start-up sequence again. The refresh line and the rail flag are asynchronous and are brought into the clock domain by a synchroniser. The four timeout lengths are multiples of a base unit and are picked by a two-bit select. All durations are cycle-count parameters, so a simulation can shrink them.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rail_ok` is low, and while `por_n` is asserted, `wd_rst_n` and `wd_armed` are both 0.
- R2: After the synchronised rail flag rises, the block waits `RST_CYC` cycles with `wd_rst_n` low. Refresh edges that reach the control logic within that window are ignored: a rising edge sampled before edge k+RST_CYC after the rail flag was applied before edge k does not arm.
- R3: Arming takes a low-to-high refresh transition. Before the first arming, a falling transition has no effect, and `wd_rst_n` stays low until arming.
- R4: While armed, a rising or a falling refresh transition restarts the timeout. Toggling with a period of exactly L cycles, or a one-cycle pulse, never lets the watchdog expire.
- R5: If no refresh transition reaches the armed watchdog for L cycles, `wd_armed` drops and `wd_rst_n` goes low for exactly `RST_CYC` cycles. An input that last changed before clock edge k gives `wd_rst_n` low from edge k+L+2.
- R6: After a timeout pulse, `wd_rst_n` returns high with `wd_armed` low. Only a new rising refresh edge re-arms; a falling edge is ignored.
- R7: The timeout is L = (`tmo_sel` + 1) × `TMO_UNIT_CYC` cycles. Select codes 0, 1, 2 and 3 give 1, 2, 3 and 4 units, which are 50, 100, 150 and 200 ms with the default parameters at 100 MHz.
- R8: A rail drop applied before edge k forces `wd_rst_n` and `wd_armed` low from edge k+2. The watchdog stays disarmed with no counting until the rail returns and the full `RST_CYC` window elapses again.
- R9: Inputs pass `SYNC_STAGES` (default 2) flops. A refresh change applied before edge k takes effect at edge k+2. A high pulse one clock wide is seen as two transitions, so the clock period must not exceed the shortest refresh pulse (80 ns requires at least 12.5 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| kick_in | input | 1 | Asynchronous refresh line from the processor |
| rail_ok | input | 1 | Asynchronous supply-good flag from the rail monitor |
| tmo_sel | input | 2 | Timeout option select, code c gives (c+1) units |
| wd_rst_n | output | 1 | Reset to the processor, active low |
| wd_armed | output | 1 | High while the watchdog is armed and counting |

## Verification
The bench runs a reduced configuration and sweeps all four timeout codes. For each code it toggles at exactly the limit period and then checks the exact cycle of expiry; an off-by-one counter would either fire during legal refresh or fire one cycle late. It places a rising edge at the last cycle of the start-up window and again one cycle later. A design that opened the window early would arm on the first of these. It also sends falling edges while the block is disarmed, which a design arming on either edge would accept, and drops the rail while the block is armed and while the refresh line is toggling, which catches a design whose timer keeps running through an undervoltage.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [2:0] {
      ST_SETTLE     = 3'd0,
      ST_WAIT_FIRST = 3'd1,
      ST_ARMED      = 3'd2,
      ST_PULSE      = 3'd3,
      ST_WAIT_REARM = 3'd4
   } wdog_state_e;

   localparam int unsigned SEL_W    = 2;
   localparam int unsigned NUM_OPTS = 4;

endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("wdog_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/wdog_edge.sv
module wdog_edge (
   input  logic clk,
   input  logic por_n,
   input  logic lvl,
   output logic rise,
   output logic any
);

   logic prev;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign any  = lvl ^ prev;

endmodule

// File: rtl/wdog_limit.sv
module wdog_limit #(
   parameter int unsigned UNIT  = 20,
   parameter int unsigned CW    = 8,
   parameter int unsigned STYLE = 0
) (
   input  logic [wdog_pkg::SEL_W-1:0] sel,
   output logic [CW-1:0]              limit
);

   localparam logic [CW-1:0] U1 = CW'(UNIT);
   localparam logic [CW-1:0] U2 = CW'(2 * UNIT);
   localparam logic [CW-1:0] U3 = CW'(3 * UNIT);
   localparam logic [CW-1:0] U4 = CW'(4 * UNIT);

   if (STYLE > 1) begin : g_bad_style
      $error("wdog_limit: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_mult
      always_comb limit = U1 * (CW'(sel) + CW'(1));
   end else begin : g_table
      always_comb begin
         case (sel)
            2'd0:    limit = U1;
            2'd1:    limit = U2;
            2'd2:    limit = U3;
            default: limit = U4;
         endcase
      end
   end

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
   parameter int unsigned RST_CYC      = 100_000,
   parameter int unsigned TMO_UNIT_CYC = 5_000_000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned LIMIT_STYLE  = 0
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       kick_in,
   input  logic       rail_ok,
   input  logic [1:0] tmo_sel,
   output logic       wd_rst_n,
   output logic       wd_armed
);

   import wdog_pkg::*;

   localparam int unsigned MAX_LIM = NUM_OPTS * TMO_UNIT_CYC;
   localparam int unsigned CNT_MAX = (MAX_LIM > RST_CYC) ? MAX_LIM : RST_CYC;
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);

   if (RST_CYC < 2) begin : g_bad_rst
      $error("wdog_supervisor: RST_CYC must be at least 2");
   end
   if (TMO_UNIT_CYC < 1) begin : g_bad_unit
      $error("wdog_supervisor: TMO_UNIT_CYC must be at least 1");
   end

   logic [1:0] raw_in, sync_out;
   logic       kick_s, rail_s, kick_rise, kick_any;
   logic [CW-1:0] lim, lim_last;

   assign raw_in = {rail_ok, kick_in};

   wdog_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign kick_s = sync_out[0];
   assign rail_s = sync_out[1];

   wdog_edge u_edge (
      .clk   (clk),
      .por_n (por_n),
      .lvl   (kick_s),
      .rise  (kick_rise),
      .any   (kick_any)
   );

   wdog_limit #(.UNIT(TMO_UNIT_CYC), .CW(CW), .STYLE(LIMIT_STYLE)) u_limit (
      .sel   (tmo_sel),
      .limit (lim)
   );

   assign lim_last = lim - CW'(1);

   wdog_state_e st, st_n;
   logic [CW-1:0] cnt, cnt_n;

   always_comb begin
      st_n  = st;
      cnt_n = cnt;
      if (!rail_s) begin
         st_n  = ST_SETTLE;
         cnt_n = '0;
      end else begin
         case (st)
            ST_SETTLE: begin
               if (cnt == RST_LAST) begin
                  st_n  = ST_WAIT_FIRST;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_WAIT_FIRST, ST_WAIT_REARM: begin
               if (kick_rise) begin
                  st_n  = ST_ARMED;
                  cnt_n = '0;
               end
            end
            ST_ARMED: begin
               if (kick_any) begin
                  cnt_n = '0;
               end else if (cnt == lim_last) begin
                  st_n  = ST_PULSE;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            ST_PULSE: begin
               if (cnt == RST_LAST) begin
                  st_n  = ST_WAIT_REARM;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt + 1'b1;
               end
            end
            default: begin
               st_n  = ST_SETTLE;
               cnt_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st  <= ST_SETTLE;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end
   end

   assign wd_rst_n = (st == ST_ARMED) || (st == ST_WAIT_REARM);
   assign wd_armed = (st == ST_ARMED);

   // R1, R8: a bad rail forces reset on the following cycle
   a_r8_rail_forces_reset: assert property (@(posedge clk) disable iff (!por_n)
      !rail_s |=> (!wd_rst_n && !wd_armed));

   // R2: the return of the rail never arms in the next cycle
   a_r2_no_arm_on_rail_return: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rail_s) |=> !wd_armed);

   // R3: arming is always preceded by a detected rising edge
   a_r3_arm_needs_rise: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wd_armed) |-> $past(kick_rise));

   // R4: a detected transition while armed with a good rail keeps it armed
   a_r4_edge_keeps_armed: assert property (@(posedge clk) disable iff (!por_n)
      (wd_armed && kick_any && rail_s) |=> wd_armed);

   // R5: a timeout with a good rail is followed by reset held low
   a_r5_pulse_held_low: assert property (@(posedge clk) disable iff (!por_n)
      ($fell(wd_armed) && rail_s) |=> !wd_rst_n);

   // R6: leaving the disarmed-released state needs a rising edge or a rail drop
   a_r6_rearm_only_on_rise: assert property (@(posedge clk) disable iff (!por_n)
      (st == ST_WAIT_REARM && !kick_rise && rail_s) |=> (wd_rst_n && !wd_armed));

   // R7: the shared counter stays inside its range
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
      cnt <= CW'(CNT_MAX));

endmodule

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;

   localparam int RST  = 12;
   localparam int UNIT = 20;

   logic       clk = 1'b0;
   logic       por_n;
   logic       kick_in;
   logic       rail_ok;
   logic [1:0] tmo_sel;
   logic       wd_rst_n;
   logic       wd_armed;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   wdog_supervisor #(
      .RST_CYC      (RST),
      .TMO_UNIT_CYC (UNIT),
      .SYNC_STAGES  (2),
      .LIMIT_STYLE  (1)
   ) uut (
      .clk      (clk),
      .por_n    (por_n),
      .kick_in  (kick_in),
      .rail_ok  (rail_ok),
      .tmo_sel  (tmo_sel),
      .wd_rst_n (wd_rst_n),
      .wd_armed (wd_armed)
   );

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      por_n = 1'b0; rail_ok = 1'b0; kick_in = 1'b0; tmo_sel = 2'd0;
      adv(3);
      chk("R1 reset state rst", wd_rst_n, 1'b0);
      chk("R1 reset state armed", wd_armed, 1'b0);

      por_n = 1'b1;
      for (int i = 0; i < 30; i++) begin
         kick_in = ~kick_in;
         adv(1);
      end
      kick_in = 1'b0;
      adv(3);
      chk("R1 rail low rst", wd_rst_n, 1'b0);
      chk("R1 rail low armed", wd_armed, 1'b0);

      // rail returns; rising edge lands on the last cycle of the window
      rail_ok = 1'b1;
      adv(RST - 1);
      kick_in = 1'b1;
      adv(6);
      chk("R2 edge in window ignored armed", wd_armed, 1'b0);
      chk("R2 edge in window ignored rst", wd_rst_n, 1'b0);

      kick_in = 1'b0;
      adv(6);
      chk("R3 falling edge no arm", wd_armed, 1'b0);
      chk("R3 rst low until armed", wd_rst_n, 1'b0);

      kick_in = 1'b1;
      adv(2);
      chk("R9 not yet armed after two edges", wd_armed, 1'b0);
      adv(1);
      chk("R9 armed at third edge", wd_armed, 1'b1);
      chk("R3 rst released on arming", wd_rst_n, 1'b1);

      for (int s = 0; s < 4; s++) begin
         int lim;
         tmo_sel = 2'(s);
         lim = (s + 1) * UNIT;
         if (!wd_armed) begin
            kick_in = 1'b1;
            adv(3);
            chk("R6 rearm on rising edge", wd_armed, 1'b1);
            chk("R6 rst high when rearmed", wd_rst_n, 1'b1);
         end
         for (int t = 0; t < 3; t++) begin
            kick_in = ~kick_in;
            adv(lim);
            chk("R4 toggle at limit keeps rst high", wd_rst_n, 1'b1);
            chk("R4 toggle at limit keeps armed", wd_armed, 1'b1);
         end
         kick_in = ~kick_in;
         adv(1);
         kick_in = ~kick_in;
         adv(lim);
         chk("R4 one-cycle pulse refreshes", wd_rst_n, 1'b1);
         adv(2);
         chk("R7 still high one cycle before expiry", wd_rst_n, 1'b1);
         adv(1);
         chk("R7 expiry at exact limit rst", wd_rst_n, 1'b0);
         chk("R5 disarmed on expiry", wd_armed, 1'b0);
         adv(RST - 1);
         chk("R5 pulse still low at last cycle", wd_rst_n, 1'b0);
         adv(1);
         chk("R5 pulse ends after reset period", wd_rst_n, 1'b1);
         chk("R6 disarmed after pulse", wd_armed, 1'b0);
         if (kick_in) begin
            kick_in = 1'b0;
            adv(5);
            chk("R6 falling edge does not rearm", wd_armed, 1'b0);
            chk("R6 rst stays high while disarmed", wd_rst_n, 1'b1);
         end
      end

      // rail drop while armed
      kick_in = 1'b1;
      adv(3);
      chk("R6 armed before rail test", wd_armed, 1'b1);
      adv(5);
      rail_ok = 1'b0;
      adv(2);
      chk("R8 rst high before sync delay", wd_rst_n, 1'b1);
      adv(1);
      chk("R8 rail drop forces rst", wd_rst_n, 1'b0);
      chk("R8 rail drop disarms", wd_armed, 1'b0);
      for (int i = 0; i < 100; i++) begin
         kick_in = ~kick_in;
         adv(1);
      end
      kick_in = 1'b0;
      adv(3);
      chk("R8 held in reset during rail low", wd_rst_n, 1'b0);
      chk("R8 no arming during rail low", wd_armed, 1'b0);

      rail_ok = 1'b1;
      adv(RST);
      kick_in = 1'b1;
      adv(2);
      chk("R2 first accepted edge not yet armed", wd_armed, 1'b0);
      adv(1);
      chk("R2 armed after full window", wd_armed, 1'b1);
      chk("R8 rst released after recovery", wd_rst_n, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule